// File: doc/BRIEF.md
# Event Interrupt Collector with CRC-Error Busy Hold

This block gathers fourteen single-cycle event pulses from a card-side data link into sticky status flags. Firmware chooses which flags may reach its single interrupt line through an enable mask. It acknowledges a flag by writing a one to that bit of a clear register. A small word-addressed register port reaches the status, mask, clear and control words. Status and mask are read back whole. The clear word always reads as zero.

The block also runs the recovery handshake for a receive CRC error. The error drops the link-enable control bit. If that bit was set and busy-on-error is enabled, the block also raises a busy output toward the link. Busy stays high until firmware writes the enable bit back to one. A separate control bit lets an acknowledge or negative-acknowledge event from the host produce a one-cycle TX flush strobe by itself. Another control bit is passed out to select how the host interrupt is timed on the bus side.

Top module: `evt_irq_busy_ctrl`

## Requirements
- R1: A pulse on `evt_i[k]` sets status bit k on that clock edge. The bit order, from 0 upward, is: RX almost full, function-1 enable, RX overrun, RX underrun, TX overrun, TX underrun, ACK, NACK, write retry, PHY interface error, card reset, PHY interrupt, CRC error, host message ready.
- R2: A status bit stays set until a write to address 2 carries a one in that bit position. Address 2 always reads as zero, and a zero written there leaves the bit unchanged.
- R3: When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R4: The mask at address 1 resets to all fourteen bits set. `irq_o` is high exactly when some status bit is set and its mask bit is 1, and it follows the registers with no added delay.
- R5: Address 0 reads the status and address 1 reads the mask. Address 3 reads the control word, which resets to 0x7: bit 0 link enable, bit 1 busy-on-error, bit 2 TX auto-flush, bit 3 host-interrupt timing select. Unused upper bits read as zero.
- R6: A CRC error (event bit 12) arriving while control bits 0 and 1 are both set raises `busy_o` on the following clock and clears control bit 0.
- R7: A CRC error always clears control bit 0. If bit 0 or bit 1 was clear at the time of the error, `busy_o` is not raised by it.
- R8: A write to address 3 with bit 0 set drops `busy_o` on the next clock and sets bit 0. If a CRC error arrives in the same cycle, the error wins: bit 0 ends clear and busy is not released.
- R9: When control bit 2 is set, an ACK (bit 6) or NACK (bit 7) event produces a one-cycle `tx_flush_o` pulse in the following cycle. When bit 2 is clear, no pulse is produced.
- R10: `host_sync_o` always equals control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 14 | Event pulses, one per status bit |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 status, 1 mask, 2 clear, 3 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Combined masked interrupt |
| busy_o | output | 1 | Busy hold after a CRC error |
| tx_flush_o | output | 1 | One-cycle TX flush strobe |
| host_sync_o | output | 1 | Host interrupt timing select |

## Verification
The bound checker watches every cycle for several properties. A pending flag never drops unless it was cleared, and a pulsed event always lands in the status. Busy is never high while the enable bit is set. A CRC error taken with both enables set always produces busy, and an ACK or NACK with auto-flush enabled always produces the flush strobe. Some behaviours can only be shown by the bench's scenarios, compared against its cycle-by-cycle model: event-over-clear precedence, CRC-over-release precedence, the masked interrupt value, the register read-back layout, and the absence of busy when an enable was off.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

   typedef enum logic [1:0] {
      RA_STATUS = 2'd0,
      RA_MASK   = 2'd1,
      RA_CLEAR  = 2'd2,
      RA_CTRL   = 2'd3
   } reg_addr_e;

   typedef struct packed {
      logic host_sync;
      logic auto_flush;
      logic busy_on_crc;
      logic link_en;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);
   localparam ctrl_t CTRL_RST = '{host_sync: 1'b0, auto_flush: 1'b1,
                                  busy_on_crc: 1'b1, link_en: 1'b1};

   localparam int EV_ACK  = 6;
   localparam int EV_NACK = 7;
   localparam int EV_CRC  = 12;
   localparam int EV_NUM  = 14;

endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
   parameter int N_EVT = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_i,
   input  logic [N_EVT-1:0] clr_i,
   input  logic             mask_we,
   input  logic [N_EVT-1:0] mask_d,
   output logic [N_EVT-1:0] status_o,
   output logic [N_EVT-1:0] mask_o
);

   for (genvar b = 0; b < N_EVT; b++) begin : g_bit
      logic st_q;
      logic mk_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q <= 1'b0;
         end else if (evt_i[b]) begin
            st_q <= 1'b1;
         end else if (clr_i[b]) begin
            st_q <= 1'b0;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mk_q <= 1'b1;
         end else if (mask_we) begin
            mk_q <= mask_d[b];
         end
      end

      assign status_o[b] = st_q;
      assign mask_o[b]   = mk_q;
   end

endmodule

// File: rtl/evt_crc_busy.sv
module evt_crc_busy
   import evt_irq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  crc_evt_i,
   input  logic  ctrl_we,
   input  ctrl_t ctrl_d,
   output ctrl_t ctrl_o,
   output logic  busy_o
);

   ctrl_t ctrl_q;
   logic  busy_q;
   logic  arm;

   assign arm = ctrl_q.link_en & ctrl_q.busy_on_crc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
      end else begin
         if (ctrl_we) begin
            ctrl_q <= ctrl_d;
         end
         if (crc_evt_i) begin
            ctrl_q.link_en <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (crc_evt_i) begin
         busy_q <= busy_q | arm;
      end else if (ctrl_we && ctrl_d.link_en) begin
         busy_q <= 1'b0;
      end
   end

   assign ctrl_o = ctrl_q;
   assign busy_o = busy_q;

endmodule

// File: rtl/evt_flush_gen.sv
module evt_flush_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_i,
   input  logic nack_i,
   input  logic enable_i,
   output logic flush_o
);

   logic flush_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_q <= 1'b0;
      end else begin
         flush_q <= enable_i & (ack_i | nack_i);
      end
   end

   assign flush_o = flush_q;

endmodule

// File: rtl/evt_irq_busy_ctrl.sv
module evt_irq_busy_ctrl
   import evt_irq_pkg::*;
#(
   parameter int N_EVT    = EV_NUM,
   parameter int DATA_W   = 32,
   parameter int CRC_IDX  = EV_CRC,
   parameter int ACK_IDX  = EV_ACK,
   parameter int NACK_IDX = EV_NACK,
   parameter bit IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_EVT-1:0]  evt_i,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_o,
   output logic              busy_o,
   output logic              tx_flush_o,
   output logic              host_sync_o
);

   localparam int PAD_EVT  = DATA_W - N_EVT;
   localparam int PAD_CTRL = DATA_W - CTRL_W;

   if (N_EVT > DATA_W || CTRL_W > DATA_W) begin : g_bad_width
      initial $fatal(1, "evt_irq_busy_ctrl: event or control word wider than data bus");
   end
   if (CRC_IDX >= N_EVT || ACK_IDX >= N_EVT || NACK_IDX >= N_EVT) begin : g_bad_index
      initial $fatal(1, "evt_irq_busy_ctrl: event index outside status word");
   end

   reg_addr_e    addr;
   logic [N_EVT-1:0] clr_bits;
   logic [N_EVT-1:0] status_q;
   logic [N_EVT-1:0] mask_q;
   ctrl_t        ctrl_q;
   logic         pend;

   assign addr     = reg_addr_e'(reg_addr);
   assign clr_bits = (reg_we && addr == RA_CLEAR) ? reg_wdata[N_EVT-1:0] : '0;

   evt_status_bank #(.N_EVT(N_EVT)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i),
      .clr_i    (clr_bits),
      .mask_we  (reg_we && addr == RA_MASK),
      .mask_d   (reg_wdata[N_EVT-1:0]),
      .status_o (status_q),
      .mask_o   (mask_q)
   );

   evt_crc_busy u_busy (
      .clk       (clk),
      .rst_n     (rst_n),
      .crc_evt_i (evt_i[CRC_IDX]),
      .ctrl_we   (reg_we && addr == RA_CTRL),
      .ctrl_d    (ctrl_t'(reg_wdata[CTRL_W-1:0])),
      .ctrl_o    (ctrl_q),
      .busy_o    (busy_o)
   );

   evt_flush_gen u_flush (
      .clk      (clk),
      .rst_n    (rst_n),
      .ack_i    (evt_i[ACK_IDX]),
      .nack_i   (evt_i[NACK_IDX]),
      .enable_i (ctrl_q.auto_flush),
      .flush_o  (tx_flush_o)
   );

   assign pend = |(status_q & mask_q);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pend;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = pend;
   end

   always_comb begin
      unique case (addr)
         RA_STATUS: reg_rdata = {{PAD_EVT{1'b0}}, status_q};
         RA_MASK:   reg_rdata = {{PAD_EVT{1'b0}}, mask_q};
         RA_CTRL:   reg_rdata = {{PAD_CTRL{1'b0}}, ctrl_q};
         default:   reg_rdata = '0;
      endcase
   end

   assign host_sync_o = ctrl_q.host_sync;

endmodule

// File: rtl/evt_irq_busy_chk.sv
module evt_irq_busy_chk
   import evt_irq_pkg::*;
#(
   parameter int N_EVT    = EV_NUM,
   parameter int DATA_W   = 32,
   parameter int CRC_IDX  = EV_CRC,
   parameter int ACK_IDX  = EV_ACK,
   parameter int NACK_IDX = EV_NACK,
   parameter bit IRQ_REG  = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_EVT-1:0]  evt_i,
   input logic              reg_we,
   input logic [1:0]        reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              irq_o,
   input logic              busy_o,
   input logic              tx_flush_o,
   input logic [N_EVT-1:0]  status_q,
   input logic [CTRL_W-1:0] ctrl_bits
);

   logic [N_EVT-1:0] clr_seen;
   assign clr_seen = (reg_we && reg_addr == 2'd2) ? reg_wdata[N_EVT-1:0] : '0;

   AST_EVENT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R1

   AST_STICKY_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(status_q) & ~$past(clr_seen)) & ~status_q) == '0)); // R2

   AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (!IRQ_REG && irq_o) |-> (status_q != '0)); // R4

   AST_CRC_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[CRC_IDX] && ctrl_bits[0] && ctrl_bits[1]) |=> (busy_o && !ctrl_bits[0])); // R6

   AST_BUSY_EXCLUDES_EN: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !ctrl_bits[0]); // R7

   AST_RELEASE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 2'd3 && reg_wdata[0] && !evt_i[CRC_IDX]) |=> !busy_o); // R8

   AST_FLUSH_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_i[ACK_IDX] || evt_i[NACK_IDX]) && ctrl_bits[2]) |=> tx_flush_o); // R9

   AST_FLUSH_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_i[ACK_IDX] || evt_i[NACK_IDX]) |=> !tx_flush_o); // R9

endmodule

bind evt_irq_busy_ctrl evt_irq_busy_chk #(
   .N_EVT(N_EVT), .DATA_W(DATA_W), .CRC_IDX(CRC_IDX),
   .ACK_IDX(ACK_IDX), .NACK_IDX(NACK_IDX), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt_i      (evt_i),
   .reg_we     (reg_we),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .irq_o      (irq_o),
   .busy_o     (busy_o),
   .tx_flush_o (tx_flush_o),
   .status_q   (status_q),
   .ctrl_bits  (ctrl_q)
);

// File: tb/evt_irq_busy_ctrl_test.sv
module evt_irq_busy_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] evt_i = '0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o, busy_o, tx_flush_o, host_sync_o;

   int n_chk = 0;
   int n_bad = 0;

   // behavioural reference state
   int m_status, m_mask, m_ctrl, m_busy, m_flush;

   always #10 clk = ~clk;

   evt_irq_busy_ctrl uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_o(irq_o), .busy_o(busy_o), .tx_flush_o(tx_flush_o),
      .host_sync_o(host_sync_o)
   );

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic model_step(int ev, int we, int addr, int wd);
      int clr, crc, n_ctrl, n_busy, old_en, old_arm;
      clr    = (we != 0 && addr == 2) ? (wd & 'h3fff) : 0;
      crc    = (ev >> 12) & 1;
      old_en = m_ctrl & 1;
      old_arm = ((m_ctrl & 3) == 3) ? 1 : 0;
      m_flush = (((ev >> 6) & 3) != 0 && ((m_ctrl >> 2) & 1) != 0) ? 1 : 0;
      m_status = (m_status & ~clr) | ev;
      if (we != 0 && addr == 1) m_mask = wd & 'h3fff;
      n_ctrl = m_ctrl;
      n_busy = m_busy;
      if (we != 0 && addr == 3) begin
         n_ctrl = wd & 'hf;
         if ((wd & 1) != 0) n_busy = 0;
      end
      if (crc != 0) begin
         n_ctrl = n_ctrl & ~1;
         n_busy = m_busy | old_arm;
      end
      if (old_en == 2) n_busy = 0;
      m_ctrl = n_ctrl;
      m_busy = n_busy;
   endtask

   function automatic int model_read(int addr);
      case (addr)
         0: return m_status;
         1: return m_mask;
         3: return m_ctrl;
         default: return 0;
      endcase
   endfunction

   // drive one cycle from a falling edge, compare at the next falling edge
   task automatic cyc(int ev, int we, int addr, int wd, string tag);
      evt_i     = ev[13:0];
      reg_we    = (we != 0);
      reg_addr  = addr[1:0];
      reg_wdata = wd;
      @(posedge clk);
      model_step(ev, we, addr, wd);
      @(negedge clk);
      evt_i  = '0;
      reg_we = 1'b0;
      check({tag, " R4 irq"},   int'(irq_o), ((m_status & m_mask) != 0) ? 1 : 0);
      check({tag, " R6 busy"},  int'(busy_o), m_busy);
      check({tag, " R9 flush"}, int'(tx_flush_o), m_flush);
      check({tag, " R10 hsync"}, int'(host_sync_o), (m_ctrl >> 3) & 1);
      check({tag, " R5 rdata"}, int'(reg_rdata), model_read(addr));
   endtask

   task automatic rd(int addr, string tag);
      cyc(0, 0, addr, 0, tag);
   endtask

   initial begin
      m_status = 0; m_mask = 'h3fff; m_ctrl = 7; m_busy = 0; m_flush = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      reg_addr = 2'd1; #1 check("R4 mask reset", int'(reg_rdata), 'h3fff);
      reg_addr = 2'd3; #1 check("R5 ctrl reset", int'(reg_rdata), 7);
      reg_addr = 2'd0; #1 check("R1 status reset", int'(reg_rdata), 0);
      check("R6 busy reset", int'(busy_o), 0);
      check("R4 irq reset", int'(irq_o), 0);

      // R1: each event lands in its own bit
      for (int k = 0; k < 14; k++) begin
         if (k == 12) continue;
         cyc(1 << k, 0, 0, 0, "R1 single event");
         cyc(0, 1, 2, 1 << k, "R2 clear one");
         rd(0, "R2 after clear");
      end
      // R2: zero write to clear is harmless, clear reads zero
      cyc('h0030, 0, 0, 0, "R1 pair");
      cyc(0, 1, 2, 0, "R2 zero clear");
      rd(0, "R2 still set");
      rd(2, "R2 clear reads zero");
      // R3: event and clear on the same bit
      cyc('h0010, 1, 2, 'h0030, "R3 collide");
      rd(0, "R3 kept");
      cyc(0, 1, 2, 'h3fff, "R2 clear all");
      // R4: masking
      cyc(0, 1, 1, 'h0001, "R4 mask one");
      cyc('h0002, 0, 1, 0, "R4 masked event");
      check("R4 masked irq low", int'(irq_o), 0);
      cyc('h0001, 0, 0, 0, "R4 unmasked event");
      check("R4 unmasked irq high", int'(irq_o), 1);
      cyc(0, 1, 1, 'h3fff, "R4 unmask all");
      cyc(0, 1, 2, 'h3fff, "R2 clear all");
      // R6: CRC with both enables
      cyc(1 << 12, 0, 3, 0, "R6 crc armed");
      check("R6 busy raised", int'(busy_o), 1);
      check("R6 enable dropped", int'(reg_rdata) & 1, 0);
      // R7: second CRC while enable is low
      cyc(1 << 12, 0, 3, 0, "R7 crc while busy");
      // R8: CRC beats release in same cycle
      cyc(1 << 12, 1, 3, 'h7, "R8 crc vs release");
      check("R8 busy held", int'(busy_o), 1);
      cyc(0, 1, 3, 'h7, "R8 release");
      check("R8 busy dropped", int'(busy_o), 0);
      // R7: busy-on-error disabled
      cyc(0, 1, 3, 'h5, "R7 no busy mode");
      cyc(1 << 12, 0, 3, 0, "R7 crc unarmed");
      check("R7 no busy", int'(busy_o), 0);
      cyc(0, 1, 3, 'h7, "R5 restore ctrl");
      // R9: auto flush on and off
      cyc(1 << 6, 0, 0, 0, "R9 ack flush");
      check("R9 flush pulse", int'(tx_flush_o), 1);
      rd(0, "R9 flush one cycle");
      cyc(1 << 7, 0, 0, 0, "R9 nack flush");
      cyc(0, 1, 3, 'h3, "R9 disable flush");
      cyc(1 << 6, 0, 0, 0, "R9 ack no flush");
      check("R9 no flush", int'(tx_flush_o), 0);
      // R10
      cyc(0, 1, 3, 'hf, "R10 hsync on");
      cyc(0, 1, 3, 'h7, "R10 hsync off");
      cyc(0, 1, 2, 'h3fff, "R2 clear all");
      // mixed traffic from an LFSR
      begin
         int s;
         s = 'h1234abcd;
         for (int i = 0; i < 400; i++) begin
            int ev, we, ad, wd;
            s  = (s << 1) ^ (((s >> 31) & 1) != 0 ? 'h04c11db7 : 0);
            ev = ((s & 'h7) == 0) ? ((s >> 4) & 'h3fff) : 0;
            we = (s >> 20) & 1;
            ad = (s >> 21) & 3;
            wd = (s >> 8);
            cyc(ev, we, ad, wd, "R1 R2 R3 R6 R7 R8 R9 mixed");
         end
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule